// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Cache

This block caches recently used virtual-to-physical page mappings. A lookup presents a virtual page number, the current address-space identifier (ASID) and an access-is-write flag. Every stored entry is compared against the request at the same time. One cycle later the block reports hit or miss, the physical frame number and the entry's writable flag. A miss also signals that a refill is needed. A write that hits a read-only mapping raises a protection fault.

A separate fill port installs the mapping that a page walker outside this block has fetched. The slot is chosen in this order:
1. an entry that already holds the same page number and ASID, which is overwritten in place;
2. otherwise the lowest-numbered free slot;
3. otherwise the slot named by a round-robin pointer.

Because every entry carries an ASID, a context switch does not force a purge. Software can still clear the whole cache, or only the entries of one ASID, in a single cycle.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when some valid entry holds both the requested page number and the requested ASID. `rsp_pfn` and `rsp_writable` then return that entry's frame number and writable flag.
- R2: An entry whose page number matches but whose ASID differs from `lk_asid` produces a miss.
- R3: After reset every entry is invalid, and a lookup misses. Invalid entries never hit.
- R4: The result appears in the cycle after `lk_req` is sampled high.
   - `rsp_done` is 1 in that cycle, and exactly one of `rsp_hit` and `rsp_miss` is 1; `rsp_miss` is the refill request.
   - When the lookup misses, `rsp_pfn`, `rsp_writable` and `rsp_fault` are 0.
   - In a cycle that follows no request, all `rsp_*` outputs are 0.
- R5: A lookup with `lk_wr`=1 that hits an entry whose writable flag is 0 sets `rsp_fault`=1. `rsp_hit` stays 1 and the frame number is still returned. A read of the same entry, or a write to a writable entry, gives `rsp_fault`=0.
- R6: `flush_all` invalidates every entry in one cycle, so that every later lookup misses until a refill.
- R7: `flush_asid_en` (with `flush_all` low) invalidates exactly the valid entries whose ASID equals `flush_asid` and leaves all other entries untouched.
- R8: When the cache is not full, a fill with no matching entry goes into the lowest-numbered invalid slot.
- R9: When all slots are valid, a fill with no matching entry replaces the slot named by a round-robin pointer.
   - The pointer is 0 after reset and advances by one, wrapping at the entry count, after each such replacement only.
   - Flushes do not change it.
- R10: A fill whose page number and ASID equal those of a valid entry overwrites that entry. No second copy is made and the pointer does not move.
- R11: Flushes and fills in the same cycle follow fixed rules.
   - A flush (either kind) in the same cycle as a fill takes priority, and the fill is dropped.
   - A lookup in the same cycle as a fill or flush sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_wr | input | 1 | Access is a write |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the installed mapping |
| fill_asid | input | ASID_W | ASID of the installed mapping |
| fill_pfn | input | PFN_W | Frame number of the installed mapping |
| fill_writable | input | 1 | Mapping permits writes |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries of one ASID |
| flush_asid | input | ASID_W | ASID to invalidate |
| rsp_done | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed, refill needed |
| rsp_fault | output | 1 | Write to read-only mapping |
| rsp_pfn | output | PFN_W | Translated frame number |
| rsp_writable | output | 1 | Writable flag of the hit entry |

## Verification
A wrong internal state can show up at the ports in three ways:
- A stale valid bit, a wrong ASID tag or a corrupted frame number shows up on the very next lookup of that page: the response one cycle later has the wrong hit, miss, frame or fault value.
- A mistaken victim choice or round-robin pointer stays invisible until some later lookup targets the page that should, or should not, have been evicted. That can be many fills later.
- A duplicate or missed entry after a refill, or an incomplete ASID flush, shows up only when the affected page is queried again.

The bench therefore keeps a reference copy of the slot contents and the pointer, and queries pages after long fill sequences as well as right after each update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Origin of the slot picked for a fill
   typedef enum logic [1:0] {
      VS_MATCH = 2'd0,
      VS_FREE  = 2'd1,
      VS_EVICT = 2'd2
   } vsrc_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int N      = 16,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N-1:0]                 valid_q,
   input  logic [N-1:0][VPN_W-1:0]      vpn_q,
   input  logic [N-1:0][ASID_W-1:0]     asid_q,
   input  logic [VPN_W-1:0]             lk_vpn,
   input  logic [ASID_W-1:0]            lk_asid,
   input  logic [VPN_W-1:0]             fl_vpn,
   input  logic [ASID_W-1:0]            fl_asid,
   input  logic [ASID_W-1:0]            kill_asid,
   output logic [N-1:0]                 lk_hit_vec,
   output logic [N-1:0]                 fl_dup_vec,
   output logic [N-1:0]                 kill_vec
);
   // one comparator set per slot, all evaluated in parallel
   for (genvar g = 0; g < N; g++) begin : g_slot
      assign lk_hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
      assign fl_dup_vec[g] = valid_q[g] && (vpn_q[g] == fl_vpn) && (asid_q[g] == fl_asid);
      assign kill_vec[g]   = valid_q[g] && (asid_q[g] == kill_asid);
   end

   // R10
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
   import tlb_pkg::*;
#(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     valid_q,
   input  logic [N-1:0]     dup_vec,
   input  logic             fill_go,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] ptr_q, ptr_nxt;
   logic [IDX_W-1:0] free_idx, dup_idx;
   logic             free_any;
   vsrc_e            src;

   always_comb begin
      free_idx = '0;
      free_any = 1'b0;
      dup_idx  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            free_idx = IDX_W'(i);
            free_any = 1'b1;
         end
         if (dup_vec[i]) dup_idx = IDX_W'(i);
      end
      if (|dup_vec) begin
         src    = VS_MATCH;
         victim = dup_idx;
      end else if (free_any) begin
         src    = VS_FREE;
         victim = free_idx;
      end else begin
         src    = VS_EVICT;
         victim = ptr_q;
      end
   end

   // wrap variant chosen by whether the depth is a power of two
   if ((N & (N - 1)) == 0) begin : g_wrap_pow2
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ptr_q <= '0;
      else if (fill_go && src == VS_EVICT)   ptr_q <= ptr_nxt;
   end

   // R8
   free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && src == VS_FREE) |-> !valid_q[victim]);
   // R9
   evict_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && src == VS_EVICT) |-> (&valid_q));
   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_go && src == VS_EVICT) |=> $stable(ptr_q));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_wr,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              fill_writable,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid,
   output logic              rsp_done,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_fault,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic              rsp_writable
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2)  begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (ENTRIES > 64) begin : g_big_entries $error("ENTRIES above 64 not supported"); end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic [ENTRIES-1:0]              valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
   logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
   logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
   logic [ENTRIES-1:0]              wr_q;

   logic [ENTRIES-1:0] hit_vec, dup_vec, kill_vec;
   logic [IDX_W-1:0]   victim;
   logic               fill_go, hit_any, wr_sel;
   logic [PFN_W-1:0]   pfn_sel;

   // any flush takes priority over a fill in the same cycle
   assign fill_go = fill_en && !flush_all && !flush_asid_en;

   tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
      .clk(clk), .rst_n(rst_n),
      .valid_q(valid_q), .vpn_q(vpn_q), .asid_q(asid_q),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .fl_vpn(fill_vpn), .fl_asid(fill_asid),
      .kill_asid(flush_asid),
      .lk_hit_vec(hit_vec), .fl_dup_vec(dup_vec), .kill_vec(kill_vec)
   );

   tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n),
      .valid_q(valid_q), .dup_vec(dup_vec), .fill_go(fill_go),
      .victim(victim)
   );

   // AND-OR read mux driven by the one-hot match vector
   always_comb begin
      pfn_sel = '0;
      wr_sel  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         pfn_sel = pfn_sel | ({PFN_W{hit_vec[i]}} & pfn_q[i]);
         wr_sel  = wr_sel  | (hit_vec[i] & wr_q[i]);
      end
   end
   assign hit_any = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush_all) begin
         valid_q <= '0;
      end else if (flush_asid_en) begin
         valid_q <= valid_q & ~kill_vec;
      end else if (fill_go) begin
         valid_q[victim] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         vpn_q[victim]  <= fill_vpn;
         asid_q[victim] <= fill_asid;
         pfn_q[victim]  <= fill_pfn;
         wr_q[victim]   <= fill_writable;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done     <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_pfn      <= '0;
         rsp_writable <= 1'b0;
      end else begin
         rsp_done     <= lk_req;
         rsp_hit      <= lk_req && hit_any;
         rsp_miss     <= lk_req && !hit_any;
         rsp_fault    <= lk_req && hit_any && lk_wr && !wr_sel;
         rsp_pfn      <= (lk_req && hit_any) ? pfn_sel : '0;
         rsp_writable <= lk_req && hit_any && wr_sel;
      end
   end

   function automatic logic asid_live(input logic [ENTRIES-1:0] v,
                                      input logic [ENTRIES-1:0][ASID_W-1:0] a,
                                      input logic [ASID_W-1:0] id);
      logic r;
      r = 1'b0;
      for (int i = 0; i < ENTRIES; i++) r = r | (v[i] && a[i] == id);
      return r;
   endfunction

   // R6
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_q == '0));
   // R7
   flush_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_asid_en && !flush_all) |=> !asid_live(valid_q, asid_q, $past(flush_asid)));
   // R5
   fault_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_hit && !rsp_writable));
   // R4
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_hit != rsp_miss));
   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> !(rsp_hit || rsp_miss || rsp_fault));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
   localparam int N = 16;
   localparam int VW = 20, PW = 20, AW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_req = 0, lk_wr = 0, fill_en = 0, fill_writable = 0;
   logic flush_all = 0, flush_asid_en = 0;
   logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
   logic [AW-1:0] lk_asid = '0, fill_asid = '0, flush_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic rsp_done, rsp_hit, rsp_miss, rsp_fault, rsp_writable;
   logic [PW-1:0] rsp_pfn;

   int checks = 0, failures = 0, cycles = 0;
   bit finished = 0;

   // reference model of the slots
   bit          m_v [N];
   logic [VW-1:0] m_vpn [N];
   logic [AW-1:0] m_asid [N];
   logic [PW-1:0] m_pfn [N];
   bit          m_wr [N];
   int          m_ptr = 0;

   asid_tlb u_asid_tlb (.*);

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int m_find(input logic [VW-1:0] v, input logic [AW-1:0] a);
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
      return -1;
   endfunction

   function automatic void m_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                                  input logic [PW-1:0] p, input bit w);
      int s;
      s = m_find(v, a);
      if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
      if (s < 0) begin
         s = m_ptr;
         m_ptr = (m_ptr + 1) % N;
      end
      m_v[s] = 1; m_vpn[s] = v; m_asid[s] = a; m_pfn[s] = p; m_wr[s] = w;
   endfunction

   task automatic do_fill(input logic [VW-1:0] v, input logic [AW-1:0] a,
                          input logic [PW-1:0] p, input bit w);
      fill_en = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_writable = w;
      @(negedge clk);
      fill_en = 0;
      m_fill(v, a, p, w);
   endtask

   task automatic do_flush(input bit all, input logic [AW-1:0] a);
      flush_all = all; flush_asid_en = !all; flush_asid = a;
      @(negedge clk);
      flush_all = 0; flush_asid_en = 0;
      for (int i = 0; i < N; i++) if (all || m_asid[i] == a) m_v[i] = 0;
   endtask

   // result checked one cycle after the request is sampled
   task automatic do_look(input string tag, input logic [VW-1:0] v,
                          input logic [AW-1:0] a, input bit w);
      int s;
      bit h;
      s = m_find(v, a);
      h = (s >= 0);
      lk_req = 1; lk_vpn = v; lk_asid = a; lk_wr = w;
      @(negedge clk);
      lk_req = 0;
      chk({tag, " done"}, 32'(rsp_done), 32'd1);
      chk({tag, " hit"}, 32'(rsp_hit), 32'(h));
      chk({tag, " miss"}, 32'(rsp_miss), 32'(!h));
      chk({tag, " pfn"}, 32'(rsp_pfn), h ? 32'(m_pfn[s]) : 32'd0);
      chk({tag, " wrbl"}, 32'(rsp_writable), h ? 32'(m_wr[s]) : 32'd0);
      chk({tag, " fault"}, 32'(rsp_fault), 32'(h && w && !m_wr[s]));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) m_v[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R3: reset state, idle outputs quiet (R4)
      chk("R3 reset done", 32'(rsp_done), 32'd0);
      chk("R4 idle hit", 32'(rsp_hit | rsp_miss | rsp_fault), 32'd0);
      do_look("R3 empty", 20'h11, 8'h1, 0);

      // R1, R2, R5
      do_fill(20'h12345, 8'h1, 20'hABCDE, 0);
      do_look("R1 read", 20'h12345, 8'h1, 0);
      do_look("R5 write ro", 20'h12345, 8'h1, 1);
      chk("R5 fault set", 32'(rsp_fault), 32'd1);
      do_look("R2 other asid", 20'h12345, 8'h2, 0);
      chk("R2 miss", 32'(rsp_miss), 32'd1);
      // R4 idle cycle after a result
      @(negedge clk);
      chk("R4 idle after", 32'(rsp_done | rsp_hit | rsp_miss), 32'd0);

      // R10: overwrite in place, pointer untouched
      do_fill(20'h12345, 8'h1, 20'h55555, 1);
      do_look("R10 overwrite", 20'h12345, 8'h1, 1);
      chk("R10 new pfn", 32'(rsp_pfn), 32'h55555);
      // R8: fill remaining slots 1..15
      for (int i = 1; i < N; i++) do_fill(20'(32'h100 + i), 8'(i % 3), 20'(32'h900 + i), 1);
      for (int i = 1; i < N; i++) do_look("R8 full", 20'(32'h100 + i), 8'(i % 3), 0);
      // R9: first eviction hits slot 0, then slot 1
      do_fill(20'h777, 8'h3, 20'h7, 1);
      do_look("R9 evicted slot0", 20'h12345, 8'h1, 0);
      chk("R9 slot0 gone", 32'(rsp_miss), 32'd1);
      do_fill(20'h778, 8'h3, 20'h8, 1);
      do_look("R9 evicted slot1", 20'h101, 8'h1, 0);
      chk("R9 slot1 gone", 32'(rsp_miss), 32'd1);
      do_look("R9 slot2 kept", 20'h102, 8'h2, 0);

      // R7: flush ASID 2 only
      do_flush(0, 8'h2);
      do_look("R7 asid2 gone", 20'h105, 8'h2, 0);
      chk("R7 miss", 32'(rsp_miss), 32'd1);
      do_look("R7 asid0 kept", 20'h103, 8'h0, 0);
      chk("R7 hit", 32'(rsp_hit), 32'd1);
      // R8: refill lands in lowest freed slot (2), then next eviction still uses ptr 2
      do_fill(20'h888, 8'h4, 20'h88, 0);
      do_look("R8 refill", 20'h888, 8'h4, 1);

      // R11: lookup same cycle as fill sees old contents
      lk_req = 1; lk_vpn = 20'h999; lk_asid = 8'h4; lk_wr = 0;
      fill_en = 1; fill_vpn = 20'h999; fill_asid = 8'h4; fill_pfn = 20'h99; fill_writable = 1;
      @(negedge clk);
      lk_req = 0; fill_en = 0;
      chk("R11 old contents", 32'(rsp_miss), 32'd1);
      m_fill(20'h999, 8'h4, 20'h99, 1);
      do_look("R11 after fill", 20'h999, 8'h4, 0);
      // R11: flush with fill drops the fill
      flush_all = 1; fill_en = 1; fill_vpn = 20'hAAA; fill_asid = 8'h5;
      @(negedge clk);
      flush_all = 0; fill_en = 0;
      for (int i = 0; i < N; i++) m_v[i] = 0;
      do_look("R11 fill dropped", 20'hAAA, 8'h5, 0);
      chk("R11 miss", 32'(rsp_miss), 32'd1);
      // R6
      do_look("R6 flushed", 20'h999, 8'h4, 0);
      chk("R6 miss", 32'(rsp_miss), 32'd1);

      // random mix against the model (R1 R2 R5 R8 R9 R10 R7 R6)
      for (int k = 0; k < 3000; k++) begin
         int op;
         op = int'($urandom_range(0, 99));
         if (op < 45)
            do_look("R1/R8/R9 model", 20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)),
                    1'($urandom_range(0, 1)));
         else if (op < 93)
            do_fill(20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)),
                    20'($urandom), 1'($urandom_range(0, 1)));
         else if (op < 98)
            do_flush(0, 8'($urandom_range(0, 2)));
         else
            do_flush(1, 8'h0);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule